// File: doc/BRIEF.md
# Control Chain Configuration Loader

This block sits between the chip-level tester input pins and the scan logic. It decides, pattern by pattern, whether each pin's serial stream goes to the scan path or into a dedicated control chain. That chain holds the routing configuration for the channel routers. There is one control chain per tester pin. Each chain is a run of `CHAIN_LEN` router address bits, which can cover bits for one input channel and several output channels. The chains shift on the same clock as the scan chains, so a reconfiguration costs only one load period at full shift rate.

The choice between the two modes is made in-band. A mode flag is captured at the end of every pattern load. After a control load the flag is forced to 1. After a scan load it takes the value carried on one designated pin in the final shift cycle. The pin select follows the flag in the idle cycles between loads. As long as patterns keep writing 1, scan data keeps flowing. A pattern that writes 0 makes the following load period a control reload. After reset the flag is 0, so the first load always configures the routers.

The whole configuration is presented in parallel on `cfg_bits` for the routers to decode. It holds steady except during a control load.

Top module: `cfg_chain_loader`

## Requirements
- R1: After reset, `mode_flag` is 0, `scan_sel` is 0, every bit of `cfg_bits` is 0, and `scan_out` is all zeros.
- R2: While `scan_sel` is 0, `scan_out` is all zeros. On each clock with `shift_en` high, every pin's bit enters its own chain.
- R3: While `scan_sel` is 1, `scan_out` equals `test_in` bit for bit. `cfg_bits` does not change on any clock where `shift_en` is low or `scan_sel` is 1.
- R4: A clock with `shift_en` and `shift_last` high while `scan_sel` is 0 ends a control load and sets `mode_flag` to 1.
- R5: A clock with `shift_en` and `shift_last` high while `scan_sel` is 1 ends a scan load. It loads `mode_flag` from `test_in[FLAG_PIN]` (default pin 0) sampled on that clock.
- R6: On each clock with `shift_en` low, `scan_sel` takes the value `mode_flag` held before that clock. `scan_sel` never changes on a clock with `shift_en` high.
- R7: Pin p owns the field `cfg_bits[p*CHAIN_LEN +: CHAIN_LEN]`. Each shift moves the field one place toward its most significant bit and puts the new pin bit at bit 0. After more than `CHAIN_LEN` shifts, only the last `CHAIN_LEN` bits remain.
- R8: `mode_flag` changes on no clock other than one with both `shift_en` and `shift_last` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock shared with the scan chains |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_en | input | 1 | High during each cycle of a pattern load |
| shift_last | input | 1 | High with `shift_en` on the final cycle of a load |
| test_in | input | N_PINS | Serial data from the tester input pins |
| scan_out | output | N_PINS | Pin data steered to the scan path |
| cfg_bits | output | N_PINS*CHAIN_LEN | Parallel contents of all control chains |
| scan_sel | output | 1 | Pin steering select: 1 for scan, 0 for control |
| mode_flag | output | 1 | Flag deciding the mode of the next load |

## Verification
The assertions assume that `shift_last` is only raised together with `shift_en`. They also assume at least one cycle with `shift_en` low between two loads, because only there can the select pick up a new flag. The stimulus builds every load as a run of shift cycles closed by a single `shift_last`, followed by a random gap of one to three idle cycles. Load lengths, pin data and the flag bit are random. Directed loads that are longer than a chain and only one cycle long push on the chain and flag edges.

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader #(
  parameter int N_PINS    = 4,
  parameter int CHAIN_LEN = 6,
  parameter int FLAG_PIN  = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        shift_en,
  input  logic                        shift_last,
  input  logic [N_PINS-1:0]           test_in,
  output logic [N_PINS-1:0]           scan_out,
  output logic [N_PINS*CHAIN_LEN-1:0] cfg_bits,
  output logic                        scan_sel,
  output logic                        mode_flag
);

  localparam int CFG_W = N_PINS * CHAIN_LEN;

  logic ctrl_shift;
  logic load_end;

  assign ctrl_shift = shift_en && !scan_sel;
  assign load_end   = shift_en && shift_last;
  assign scan_out   = scan_sel ? test_in : '0;

  for (genvar p = 0; p < N_PINS; p++) begin : g_chain
    logic [CHAIN_LEN-1:0] bits_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bits_q <= '0;
      else if (ctrl_shift) bits_q <= {bits_q[CHAIN_LEN-2:0], test_in[p]};
    end
    assign cfg_bits[p*CHAIN_LEN +: CHAIN_LEN] = bits_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_flag <= 1'b0;
    else if (load_end) mode_flag <= scan_sel ? test_in[FLAG_PIN] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         scan_sel <= 1'b0;
    else if (!shift_en) scan_sel <= mode_flag;
  end

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en || scan_sel) |=> $stable(cfg_bits))
    else $error("cfg_bits moved outside a control load");

  p_ctrl_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && shift_last && !scan_sel) |=> mode_flag)
    else $error("flag not set after control load");

  p_scan_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && shift_last && scan_sel) |=> (mode_flag == $past(test_in[FLAG_PIN])))
    else $error("flag not taken from scan stream");

  p_sel_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> $stable(scan_sel))
    else $error("select changed during a load");

  p_sel_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> (scan_sel == $past(mode_flag)))
    else $error("select did not follow flag");

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_en && shift_last) |=> $stable(mode_flag))
    else $error("flag changed outside load end");

  initial begin
    if (CHAIN_LEN < 2 || FLAG_PIN >= N_PINS || CFG_W < 2)
      $error("bad parameters");
  end

endmodule

// File: tb/cfg_chain_loader_bench.sv
module cfg_chain_loader_bench;
  localparam int N = 4;
  localparam int L = 6;
  localparam int FP = 0;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_en = 1'b0;
  logic shift_last = 1'b0;
  logic [N-1:0] test_in = '0;
  logic [N-1:0] scan_out;
  logic [N*L-1:0] cfg_bits;
  logic scan_sel, mode_flag;

  int errors = 0;
  int checks = 0;

  logic [N*L-1:0] m_cfg = '0;
  logic m_cf = 1'b0;
  logic m_sel = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_chain_loader #(.N_PINS(N), .CHAIN_LEN(L), .FLAG_PIN(FP)) u_cfg_chain_loader (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .shift_last(shift_last),
    .test_in(test_in), .scan_out(scan_out), .cfg_bits(cfg_bits),
    .scan_sel(scan_sel), .mode_flag(mode_flag));

  function automatic logic [N-1:0] exp_scan(logic sel, logic [N-1:0] pins);
    return sel ? pins : '0;
  endfunction

  function automatic logic [N*L-1:0] exp_shift(logic [N*L-1:0] cur, logic [N-1:0] pins);
    logic [N*L-1:0] r = cur;
    for (int p = 0; p < N; p++) r[p*L +: L] = {cur[p*L +: L-1], pins[p]};
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle(logic sh, logic last, logic [N-1:0] pins);
    shift_en = sh; shift_last = last; test_in = pins;
    #1;
    check(m_sel ? "R3 scan_out" : "R2 scan_out", 64'(scan_out), 64'(exp_scan(m_sel, pins)));
    @(posedge clk);
    if (sh && !m_sel) m_cfg = exp_shift(m_cfg, pins);
    if (sh && last) m_cf = m_sel ? pins[FP] : 1'b1;
    if (!sh) m_sel = m_cf;
    @(negedge clk);
    check("R7 cfg_bits", 64'(cfg_bits), 64'(m_cfg));
    check(sh && last ? (m_sel ? "R5 flag" : "R4 flag") : "R8 flag", 64'(mode_flag), 64'(m_cf));
    check("R6 sel", 64'(scan_sel), 64'(m_sel));
  endtask

  task automatic load(int len, logic flag_bit);
    for (int c = 0; c < len; c++) begin
      logic [N-1:0] d = N'($urandom);
      if (c == len - 1) d[FP] = flag_bit;
      cycle(1'b1, c == len - 1, d);
    end
    for (int g = 0; g < 1 + int'($urandom_range(2)); g++) cycle(1'b0, 1'b0, N'($urandom));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk);
    // R1 reset state
    test_in = N'($urandom);
    #1;
    check("R1 flag", 64'(mode_flag), 64'd0);
    check("R1 sel", 64'(scan_sel), 64'd0);
    check("R1 cfg", 64'(cfg_bits), 64'd0);
    check("R1 scan_out", 64'(scan_out), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: idle keeps select low, long control load keeps last L bits (R7)
    cycle(1'b0, 1'b0, '1);
    load(L + 3, 1'b0);
    check("R4 flag set", 64'(mode_flag), 64'd1);
    check("R6 sel high after gap", 64'(scan_sel), 64'd1);
    // directed: scan load with non-last shifts and flag 1 keeps scan mode (R3, R5)
    load(5, 1'b1);
    check("R5 flag one", 64'(mode_flag), 64'd1);
    // directed: one-cycle scan load clearing the flag
    load(1, 1'b0);
    check("R5 flag zero", 64'(mode_flag), 64'd0);
    check("R6 sel low", 64'(scan_sel), 64'd0);
    // directed: exact-length control load
    load(L, 1'b1);
    // random mix
    for (int k = 0; k < 60; k++) begin
      int len = m_sel ? 1 + int'($urandom_range(9)) : L + int'($urandom_range(3));
      logic fb = ($urandom_range(3) != 0);
      load(len, fb);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule